// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache with One-Block Victim Buffer

This block is a small data cache controller that sits between a processor port and a single memory channel. Lines are direct-mapped and hold two 32-bit words. Writes that hit update the line in place and mark it dirty, and memory sees the change only when the line is evicted. When a miss must evict a dirty line, the line is moved into a one-block victim buffer. The refill read of the new block then uses the memory channel first, and the buffered block is written out afterwards.

The processor port completes each request with a one-cycle ready pulse. A request raises ready as soon as its refill arrives, even if the victim write is still outstanding. While the victim buffer drains, hits keep completing in one cycle. A miss whose block is still in the victim buffer takes its data from the buffer and does not read memory. The memory channel carries one block transaction at a time, either a read or a write, and each transaction ends with a one-cycle done pulse.

Top module: `cwb_cache`

## Requirements
- R1: After reset, cpu_rsp_ready and mem_req_valid are low and every line is invalid, so the first access to any address misses and reads its block from memory.
- R2: A read hit raises cpu_rsp_ready one cycle after the request is presented and starts no memory transaction. Byte address bits [1:0] are ignored, bit [2] selects the word, bits [6:3] are the line index and bits [31:7] form the tag.
- R3: A write hit updates the addressed word, marks the line dirty and starts no memory transaction. The new value is returned by later reads and reaches memory when the line is evicted.
- R4: A miss reads the block at the block-aligned address (low 3 bits zero). Memory word 0 occupies data bits [31:0] and word 1 occupies bits [63:32]. A write miss merges the written word into the refilled block.
- R5: On a miss that evicts a dirty line, the refill read goes to memory before the write of the victim block. A refill request wins the channel over a buffered write that has not yet started.
- R6: On a dirty-eviction miss, cpu_rsp_ready is raised once the refill completes, before the victim write has finished.
- R7: While the victim buffer is writing to memory, hits still complete with one-cycle latency.
- R8: A miss that arrives while a victim write is in flight issues its refill read only after that write is acknowledged.
- R9: A miss whose block is held in the victim buffer, where the line being replaced is clean, completes in one cycle with the buffered data and starts no memory read.
- R10: A dirty eviction that finds the victim buffer full waits until the buffer has drained. No buffered block is overwritten before it has been written to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Request present; held with stable fields until cpu_rsp_ready |
| cpu_req_wr | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_wdata | input | 32 | Write word |
| cpu_rsp_rdata | output | 32 | Read word, valid with cpu_rsp_ready |
| cpu_rsp_ready | output | 1 | One-cycle completion pulse |
| mem_req_valid | output | 1 | Memory transaction active; held until mem_rsp_done |
| mem_req_wr | output | 1 | 1 = block write, 0 = block read |
| mem_req_addr | output | 32 | Block-aligned byte address |
| mem_req_wdata | output | 64 | Block written to memory |
| mem_rsp_rdata | input | 64 | Block read from memory, valid with mem_rsp_done |
| mem_rsp_done | input | 1 | One-cycle completion of the active transaction |

## Verification
The scoreboard compares every read response against a word-level reference memory. The bench also logs each memory transaction with its start and finish cycles. Runs of hits to a resident line, with byte offsets varied, separate correct decoding and write-back behaviour from write-through or refetching. Conflicting addresses on one index, with a slow memory, expose the order of refill and victim write and show whether ready waits for the victim. Hits and buffer-resident misses issued during a drain show whether the controller stalls behind the channel. A second dirty eviction while the buffer is still full, followed by a miss during the next drain, tells a correct stall and channel handover apart from a clobbered buffer or an overlapping transaction.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  typedef enum logic {
    ST_CMP   = 1'b0,
    ST_ALLOC = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/cwb_line_store.sv
module cwb_line_store #(
  parameter int LINES = 16,
  parameter int IDX_W = 4,
  parameter int TAG_W = 25,
  parameter int BLK_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  output logic [BLK_W-1:0] rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [BLK_W-1:0] wr_data,
  input  logic             wr_dirty
);
  logic             valid_q [LINES];
  logic             dirty_q [LINES];
  logic [TAG_W-1:0] tag_mem [LINES];
  logic [BLK_W-1:0] data_mem[LINES];

  // per-line state bits, cleared by reset
  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        valid_q[g] <= 1'b1;
        dirty_q[g] <= wr_dirty;
      end
    end
  end

  // tag and data arrays: no reset, single write port (RAM style)
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
  assign rd_data  = data_mem[rd_idx];
endmodule

// File: rtl/cwb_victim_buf.sv
module cwb_victim_buf #(
  parameter int AW    = 32,
  parameter int BLK_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [AW-1:0]    load_addr,
  input  logic [BLK_W-1:0] load_data,
  input  logic             drained,
  output logic             full,
  output logic [AW-1:0]    addr,
  output logic [BLK_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) full <= 1'b0;
    else if (load) full <= 1'b1;
    else if (drained) full <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      addr <= load_addr;
      data <= load_data;
    end
  end

  assert_no_clobber_R10: assert property (@(posedge clk) disable iff (rst)
    load |-> !full);
  assert_drain_only_full_R10: assert property (@(posedge clk) disable iff (rst)
    drained |-> full);
endmodule

// File: rtl/cwb_mem_arb.sv
module cwb_mem_arb #(
  parameter int AW    = 32,
  parameter int BLK_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_req,
  input  logic [AW-1:0]    rd_addr,
  input  logic             wr_req,
  input  logic [AW-1:0]    wr_addr,
  input  logic [BLK_W-1:0] wr_data,
  input  logic             mem_rsp_done,
  output logic             mem_req_valid,
  output logic             mem_req_wr,
  output logic [AW-1:0]    mem_req_addr,
  output logic [BLK_W-1:0] mem_req_wdata,
  output logic             rd_done,
  output logic             wr_done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req_valid <= 1'b0;
      mem_req_wr    <= 1'b0;
    end else if (mem_req_valid) begin
      if (mem_rsp_done) mem_req_valid <= 1'b0;
    end else if (rd_req) begin
      mem_req_valid <= 1'b1;
      mem_req_wr    <= 1'b0;
    end else if (wr_req) begin
      mem_req_valid <= 1'b1;
      mem_req_wr    <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!mem_req_valid) begin
      if (rd_req) mem_req_addr <= rd_addr;
      else if (wr_req) begin
        mem_req_addr  <= wr_addr;
        mem_req_wdata <= wr_data;
      end
    end
  end

  assign rd_done = mem_req_valid && mem_rsp_done && !mem_req_wr;
  assign wr_done = mem_req_valid && mem_rsp_done &&  mem_req_wr;

  assert_channel_held_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_rsp_done) |=>
      (mem_req_valid && $stable(mem_req_wr) && $stable(mem_req_addr)));
  assert_refill_first_R5: assert property (@(posedge clk) disable iff (rst)
    (!mem_req_valid && rd_req && wr_req) |=> (mem_req_valid && !mem_req_wr));
endmodule

// File: rtl/cwb_cache.sv
module cwb_cache
  import cwb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 2,
  localparam int BLK_W = DATA_W * WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_wr,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              cpu_rsp_ready,
  output logic              mem_req_valid,
  output logic              mem_req_wr,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [BLK_W-1:0]  mem_req_wdata,
  input  logic [BLK_W-1:0]  mem_rsp_rdata,
  input  logic              mem_rsp_done
);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int OFF_W  = BYTE_W + WSEL_W;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

  // address fields
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [WSEL_W-1:0] wsel;
  logic [ADDR_W-1:0] blk_addr;
  logic              unused_byte_bits;
  assign idx      = cpu_req_addr[OFF_W +: IDX_W];
  assign tag      = cpu_req_addr[ADDR_W-1 -: TAG_W];
  assign wsel     = cpu_req_addr[BYTE_W +: WSEL_W];
  assign blk_addr = {cpu_req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign unused_byte_bits = ^cpu_req_addr[BYTE_W-1:0];

  // line store
  logic             ln_valid, ln_dirty;
  logic [TAG_W-1:0] ln_tag;
  logic [BLK_W-1:0] ln_data;
  logic             st_wr_en, st_dirty;
  logic [BLK_W-1:0] merged;

  cwb_line_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .BLK_W(BLK_W)) u_store (
    .clk(clk), .rst(rst),
    .rd_idx(idx), .rd_valid(ln_valid), .rd_dirty(ln_dirty), .rd_tag(ln_tag), .rd_data(ln_data),
    .wr_en(st_wr_en), .wr_idx(idx), .wr_tag(tag), .wr_data(merged), .wr_dirty(st_dirty)
  );

  // victim buffer
  logic              vb_load, vb_full, wr_done, rd_done;
  logic [ADDR_W-1:0] vb_addr, victim_addr;
  logic [BLK_W-1:0]  vb_data;
  assign victim_addr = {ln_tag, idx, {OFF_W{1'b0}}};

  cwb_victim_buf #(.AW(ADDR_W), .BLK_W(BLK_W)) u_vbuf (
    .clk(clk), .rst(rst),
    .load(vb_load), .load_addr(victim_addr), .load_data(ln_data),
    .drained(wr_done), .full(vb_full), .addr(vb_addr), .data(vb_data)
  );

  // memory channel
  ctl_state_e state_q, state_d;
  logic       rd_req;
  assign rd_req = (state_q == ST_ALLOC);

  cwb_mem_arb #(.AW(ADDR_W), .BLK_W(BLK_W)) u_arb (
    .clk(clk), .rst(rst),
    .rd_req(rd_req), .rd_addr(blk_addr),
    .wr_req(vb_full), .wr_addr(vb_addr), .wr_data(vb_data),
    .mem_rsp_done(mem_rsp_done),
    .mem_req_valid(mem_req_valid), .mem_req_wr(mem_req_wr),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .rd_done(rd_done), .wr_done(wr_done)
  );

  // controller
  logic             hit, vb_match, victim_dirty, accept, done_now, rdy_q;
  logic [BLK_W-1:0] base;
  logic [DATA_W-1:0] rdata_q;

  assign hit          = ln_valid && (ln_tag == tag);
  assign vb_match     = vb_full && (vb_addr == blk_addr);
  assign victim_dirty = ln_valid && ln_dirty;
  assign accept       = (state_q == ST_CMP) && cpu_req_valid && !rdy_q;

  always_comb begin
    base     = ln_data;
    st_wr_en = 1'b0;
    st_dirty = 1'b0;
    vb_load  = 1'b0;
    done_now = 1'b0;
    state_d  = state_q;
    unique case (state_q)
      ST_CMP: begin
        if (accept) begin
          if (hit) begin
            done_now = 1'b1;
            st_wr_en = cpu_req_wr;
            st_dirty = 1'b1;
          end else if (vb_match && !victim_dirty) begin
            base     = vb_data;
            done_now = 1'b1;
            st_wr_en = 1'b1;
            st_dirty = cpu_req_wr;
          end else if (!(victim_dirty && vb_full)) begin
            vb_load = victim_dirty;
            state_d = ST_ALLOC;
          end
        end
      end
      ST_ALLOC: begin
        base = mem_rsp_rdata;
        if (rd_done) begin
          done_now = 1'b1;
          st_wr_en = 1'b1;
          st_dirty = cpu_req_wr;
          state_d  = ST_CMP;
        end
      end
      default: state_d = ST_CMP;
    endcase
  end

  always_comb begin
    merged = base;
    if (cpu_req_wr) merged[wsel*DATA_W +: DATA_W] = cpu_req_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_CMP;
      rdy_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      rdy_q   <= done_now;
      if (done_now) rdata_q <= merged[wsel*DATA_W +: DATA_W];
    end
  end

  assign cpu_rsp_ready = rdy_q;
  assign cpu_rsp_rdata = rdata_q;

  assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    cpu_rsp_ready |=> !cpu_rsp_ready);
  assert_ready_after_refill_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ALLOC && rd_done) |=> cpu_rsp_ready);
endmodule

// File: tb/sim_cwb_cache.sv
module sim_cwb_cache;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req_valid = 1'b0, cpu_req_wr = 1'b0;
  logic [31:0] cpu_req_addr = '0, cpu_req_wdata = '0;
  logic [31:0] cpu_rsp_rdata;
  logic        cpu_rsp_ready;
  logic        mem_req_valid, mem_req_wr;
  logic [31:0] mem_req_addr;
  logic [63:0] mem_req_wdata;
  logic [63:0] mem_rsp_rdata = '0;
  logic        mem_rsp_done = 1'b0;

  always #10 clk = ~clk;

  cwb_cache u0 (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_wr(cpu_req_wr),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_rdata(cpu_rsp_rdata), .cpu_rsp_ready(cpu_rsp_ready),
    .mem_req_valid(mem_req_valid), .mem_req_wr(mem_req_wr),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_rdata(mem_rsp_rdata), .mem_rsp_done(mem_rsp_done)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;
  int mem_lat = 2;
  logic [63:0] mem_blocks[logic [31:0]];
  logic [31:0] ref_words[logic [31:0]];
  bit          log_wr[$];
  logic [31:0] log_addr[$];
  int          log_start[$], log_end[$];
  logic [31:0] exp_data[$];
  bit          exp_rd[$];
  string       exp_tag[$];

  function automatic logic [31:0] init_word(input logic [31:0] a);
    return (a ^ 32'h5A5A_0000) + 32'd7;
  endfunction
  function automatic logic [63:0] mem_get(input logic [31:0] b);
    if (mem_blocks.exists(b)) return mem_blocks[b];
    return {init_word(b + 32'd4), init_word(b)};
  endfunction
  function automatic logic [31:0] ref_get(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    if (ref_words.exists(w)) return ref_words[w];
    return init_word(w);
  endfunction
  function automatic int n_writes();
    int n = 0;
    foreach (log_wr[i]) if (log_wr[i]) n++;
    return n;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // memory model: one transaction at a time, done after mem_lat cycles
  initial begin
    int          st;
    bit          w;
    logic [31:0] a;
    forever begin
      @(negedge clk);
      if (mem_req_valid && !rst) begin
        st = cyc; w = mem_req_wr; a = mem_req_addr;
        if (w) mem_blocks[a] = mem_req_wdata;
        repeat (mem_lat - 1) @(negedge clk);
        if (!w) mem_rsp_rdata = mem_get(a);
        mem_rsp_done = 1'b1;
        log_wr.push_back(w); log_addr.push_back(a);
        log_start.push_back(st); log_end.push_back(cyc);
        @(negedge clk);
        mem_rsp_done = 1'b0;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (cpu_rsp_ready) begin
      if (exp_rd.size() == 0) chk(1'b0, "R2 unexpected ready", 1, 0);
      else begin
        logic [31:0] e;
        bit          r;
        string       t;
        e = exp_data.pop_front(); r = exp_rd.pop_front(); t = exp_tag.pop_front();
        if (r) chk(cpu_rsp_rdata == e, t, cpu_rsp_rdata, e);
      end
    end
  end

  // driver
  task automatic do_req(input bit w, input logic [31:0] a, input logic [31:0] d,
                        input string t, output int lat);
    int t0;
    if (w) ref_words[{a[31:2], 2'b00}] = d;
    exp_data.push_back(w ? d : ref_get(a));
    exp_rd.push_back(!w);
    exp_tag.push_back(t);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_wr = w; cpu_req_addr = a; cpu_req_wdata = d;
    t0 = cyc;
    do @(negedge clk); while (!cpu_rsp_ready);
    lat = cyc - t0;
    cpu_req_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  localparam logic [31:0] A = 32'h0000_0008, B = 32'h0000_0088, C = 32'h0000_0108;
  localparam logic [31:0] D = 32'h0000_0200, E = 32'h0000_0010;

  initial begin
    int lat, nl, nw;
    repeat (3) @(negedge clk);
    chk(!cpu_rsp_ready && !mem_req_valid, "R1 outputs in reset", {cpu_rsp_ready, mem_req_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!cpu_rsp_ready && !mem_req_valid, "R1 outputs after reset", {cpu_rsp_ready, mem_req_valid}, 0);

    // R1 / R4: cold miss, block-aligned refill
    nl = log_wr.size();
    do_req(0, A + 4, 0, "R1 cold read data", lat);
    chk(log_wr.size() == nl + 1 && !log_wr[nl], "R1 cold miss reads memory", log_wr.size(), nl + 1);
    chk(log_addr[nl] == A, "R4 refill address aligned", log_addr[nl], A);

    // R2: hits, byte offset ignored
    nl = log_wr.size();
    do_req(0, A, 0, "R2 hit word0", lat);
    chk(lat == 1, "R2 hit latency", lat, 1);
    do_req(0, A + 3, 0, "R2 byte offset ignored", lat);
    do_req(0, A + 6, 0, "R2 word select", lat);
    chk(log_wr.size() == nl, "R2 no memory traffic on hits", log_wr.size(), nl);

    // R3: write hit stays in cache
    do_req(1, A, 32'hDEAD_0001, "R3 write", lat);
    chk(lat == 1, "R3 write hit latency", lat, 1);
    do_req(0, A, 0, "R3 read back", lat);
    chk(log_wr.size() == nl, "R3 no write-through", log_wr.size(), nl);

    // R4: write miss merges into refill
    do_req(1, D + 4, 32'hBEEF_0002, "R4 write miss", lat);
    chk(log_wr.size() == nl + 1 && log_addr[nl] == D, "R4 write miss refill", log_addr[nl], D);
    do_req(0, D, 0, "R4 untouched word", lat);
    do_req(0, D + 4, 0, "R4 merged word", lat);

    // R5 / R6: dirty eviction with slow memory
    mem_lat = 20;
    nl = log_wr.size(); nw = n_writes();
    do_req(0, B, 0, "R6 refill data", lat);
    chk(n_writes() == nw, "R6 ready before victim write done", n_writes(), nw);
    chk(log_wr.size() == nl + 1 && log_addr[nl] == B, "R5 refill read first", log_addr[nl], B);

    // R7: hit during drain
    do_req(0, B + 4, 0, "R7 hit data during drain", lat);
    chk(lat == 1 && n_writes() == nw, "R7 hit latency during drain", lat, 1);

    // R9: miss on the buffered block
    do_req(0, A, 0, "R9 buffer-served data", lat);
    chk(lat == 1, "R9 buffer hit latency", lat, 1);
    chk(log_wr.size() == nl + 1 && n_writes() == nw, "R9 no memory read", log_wr.size(), nl + 1);
    while (n_writes() == nw) @(negedge clk);
    chk(log_wr[nl + 1] && log_addr[nl + 1] == A, "R5 victim written after refill", log_addr[nl + 1], A);

    // R10: second dirty eviction while buffer full
    do_req(1, A + 4, 32'h1111_2222, "R10 dirty A", lat);
    do_req(0, B, 0, "R10 evict A", lat);
    do_req(1, B, 32'h3333_4444, "R10 dirty B", lat);
    chk(lat == 1, "R10 write hit latency", lat, 1);
    nl = log_wr.size();
    do_req(0, C, 0, "R10 refill C", lat);
    chk(log_wr.size() == nl + 2 && log_wr[nl] && log_addr[nl] == A, "R10 buffered A drained first",
        log_addr[nl], A);
    chk(!log_wr[nl + 1] && log_start[nl + 1] > log_end[nl], "R10 refill after drain",
        log_start[nl + 1], log_end[nl] + 1);

    // R8: miss while B drains
    nl = log_wr.size();
    do_req(0, E, 0, "R8 data", lat);
    chk(log_wr.size() == nl + 2 && log_wr[nl] && log_addr[nl] == B, "R8 drain of B in flight",
        log_addr[nl], B);
    chk(!log_wr[nl + 1] && log_start[nl + 1] > log_end[nl], "R8 refill waits for channel",
        log_start[nl + 1], log_end[nl] + 1);

    // R3 / R10: evicted data reached memory
    mem_lat = 3;
    do_req(0, A, 0, "R3 A word0 via memory", lat);
    do_req(0, A + 4, 0, "R10 A word1 via memory", lat);
    do_req(0, B, 0, "R10 B via memory", lat);
    do_req(0, C + 4, 0, "R4 C word1", lat);
    do_req(0, D + 4, 0, "R3 D still resident", lat);
    repeat (4) @(negedge clk);
    chk(exp_rd.size() == 0, "R2 all responses seen", exp_rd.size(), 0);
    finish_run();
  end
endmodule